// File: doc/BRIEF.md
# Way-Limited Tag Directory

This block is the tag side of an N-way set-associative cache. A lookup address is cut into a set index and a tag. All N ways of that set are compared, and one cycle later the block reports a hit or a miss, the matching way and a replacement candidate. The candidate is always drawn from the lowest k ways. k is a limit that software programs at run time through a small write port and can read back at any time. This lets part of each set be reserved, for example for partitioning, without rebuilding the array.

Fills and invalidations address an entry by set and way. A separate combinational query port returns the valid bit and tag of any entry. Two counters estimate the energy cost of lookups:

- The tag counter grows by k on every lookup.
- In parallel access mode the data counter also grows by k.
- In sequential tag-then-data mode the data counter grows by one only on a hit.

Top module: `way_restricted_tags`

## Requirements
- R1: After reset the limit reads N (4 by default), every entry is invalid, both access counters are zero, `rsp_valid` is 0 and `lim_err` is 0.
- R2: A limit write with value 0 leaves the limit unchanged and raises `lim_err` for exactly the cycle after the write.
- R3: A limit write with a value from 1 to N sets the limit to that value, and a value above N sets it to N. `limit_out` shows the new value from the cycle after the write.
- R4: The set index is `lookup_addr[OFFSET_W +: SET_W]` and the tag is the address bits above it. One cycle after `lookup_valid`, `rsp_valid` is 1. `rsp_hit` is 1 when any of the N ways, including ways at or above the limit, holds a valid entry with that tag, and `rsp_way` gives the lowest such way.
- R5: `rsp_victim` is the lowest-numbered invalid way among ways 0 to k-1 of the looked-up set. If all of those ways are valid, it is way k-1.
- R6: Every lookup adds the limit in force at that lookup to `tag_acc_cnt`.
- R7: With `access_mode` = 1 (sequential), a hit adds 1 to `data_acc_cnt` and a miss adds 0.
- R8: With `access_mode` = 0 (parallel), every lookup adds the limit to `data_acc_cnt`.
- R9: `qry_valid` and `qry_tag` combinationally return the stored valid bit and tag at `qry_set`/`qry_way`.
- R10: A fill writes the tag of `fill_addr` into set `fill_addr[OFFSET_W +: SET_W]`, way `fill_way`, and sets its valid bit. An invalidate clears the valid bit at `inv_set`/`inv_way`. Both are visible the next cycle. If both hit the same entry in one cycle, the fill wins.
- R11: In a cycle without a lookup, neither access counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_wr_en | input | 1 | Limit write strobe |
| lim_wr_data | input | LIM_W (4) | Requested way limit |
| limit_out | output | LIM_W (4) | Current way limit k |
| lim_err | output | 1 | Rejected-write pulse (value 0) |
| access_mode | input | 1 | 0 parallel, 1 sequential tag-then-data |
| lookup_valid | input | 1 | Lookup request |
| lookup_addr | input | ADDR_W (16) | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W (2) | Lowest matching way (0 on miss) |
| rsp_victim | output | WAY_W (2) | Replacement candidate |
| fill_en | input | 1 | Fill strobe |
| fill_addr | input | ADDR_W (16) | Address whose set and tag are filled |
| fill_way | input | WAY_W (2) | Way to fill |
| inv_en | input | 1 | Invalidate strobe |
| inv_set | input | SET_W (4) | Set to invalidate |
| inv_way | input | WAY_W (2) | Way to invalidate |
| qry_set | input | SET_W (4) | Query set |
| qry_way | input | WAY_W (2) | Query way |
| qry_valid | output | 1 | Valid bit at the queried entry |
| qry_tag | output | TAG_W (8) | Tag at the queried entry |
| tag_acc_cnt | output | CNT_W (16) | Tag access counter |
| data_acc_cnt | output | CNT_W (16) | Data access counter |

## Verification
The bench targets the places where the limit and the full width of the array pull apart:

- **Hit above the limit.** An entry is placed in a way above the limit and then looked up. A design that compared only k ways would report a miss there.
- **Full range, first invalid way.** The limit is set so that every way below it is valid, which must pick way k-1. The limit is then raised so that the first invalid way must be found. A scan that ignored the limit, or settled on way 0, would give the wrong victim.
- **Limit writes.** Writes of 0 and of values above N check rejection and clamping.
- **Counters.** The counters are tracked across both access modes. Hits and misses in sequential mode expose a data counter that adds N instead of k, or that counts misses.
- **Fill and invalidate together.** A fill and an invalidate aimed at the same entry check the stated priority.

// File: rtl/wrt_pkg.sv
package wrt_pkg;

    // Array geometry
    localparam int unsigned WAYS     = 4;
    localparam int unsigned SETS     = 16;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned OFFSET_W = 4;
    localparam int unsigned CNT_W    = 16;

    // Derived widths
    localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int unsigned TAG_W = ADDR_W - OFFSET_W - SET_W;
    // One spare bit so that over-range requests can be expressed and clamped
    localparam int unsigned LIM_W = $clog2(WAYS + 1) + 1;

    typedef logic [SET_W-1:0]  set_idx_t;
    typedef logic [WAY_W-1:0]  way_idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LIM_W-1:0]  lim_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } tag_entry_t;

    typedef struct packed {
        logic     hit;
        way_idx_t way;
        way_idx_t victim;
    } lookup_res_t;

    typedef enum logic {
        MODE_PARALLEL   = 1'b0,
        MODE_SEQUENTIAL = 1'b1
    } access_mode_e;

    function automatic set_idx_t addr_set(addr_t a);
        return a[OFFSET_W +: SET_W];
    endfunction

    function automatic tag_t addr_tag(addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic lim_t clamp_limit(lim_t v);
        if (v > lim_t'(WAYS))
            return lim_t'(WAYS);
        return v;
    endfunction

endpackage

// File: rtl/wrt_limit_reg.sv
module wrt_limit_reg
    import wrt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  lim_t wr_data,
    output lim_t limit,
    output logic reject
);

    always_ff @(posedge clk) begin
        if (rst) begin
            limit  <= lim_t'(WAYS);
            reject <= 1'b0;
        end else begin
            reject <= 1'b0;
            if (wr_en) begin
                if (wr_data == '0)
                    reject <= 1'b1;
                else
                    limit <= clamp_limit(wr_data);
            end
        end
    end

endmodule

// File: rtl/wrt_tag_store.sv
module wrt_tag_store
    import wrt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    // lookup side
    input  set_idx_t        lk_set,
    input  tag_t            lk_tag,
    output logic [WAYS-1:0] valid_vec,
    output logic [WAYS-1:0] match_vec,
    // fill
    input  logic            wr_fill,
    input  set_idx_t        wr_set,
    input  way_idx_t        wr_way,
    input  tag_t            wr_tag,
    // invalidate
    input  logic            clr_en,
    input  set_idx_t        clr_set,
    input  way_idx_t        clr_way,
    // direct read
    input  set_idx_t        rd_set,
    input  way_idx_t        rd_way,
    output tag_entry_t      rd_entry
);

    tag_entry_t rd_per_way [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_entry_t lines [SETS];
        logic       fill_here;
        logic       clr_here;

        assign fill_here = wr_fill && (wr_way == way_idx_t'(w));
        // a fill to the same entry in the same cycle takes priority
        assign clr_here  = clr_en && (clr_way == way_idx_t'(w))
                           && !(fill_here && (wr_set == clr_set));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++)
                    lines[s] <= '0;
            end else begin
                if (fill_here)
                    lines[wr_set] <= '{valid: 1'b1, tag: wr_tag};
                if (clr_here)
                    lines[clr_set].valid <= 1'b0;
            end
        end

        assign valid_vec[w]  = lines[lk_set].valid;
        assign match_vec[w]  = lines[lk_set].valid && (lines[lk_set].tag == lk_tag);
        assign rd_per_way[w] = lines[rd_set];
    end

    assign rd_entry = rd_per_way[rd_way];

endmodule

// File: rtl/wrt_victim_pick.sv
module wrt_victim_pick
    import wrt_pkg::*;
(
    input  logic [WAYS-1:0] valid_vec,
    input  lim_t            limit,
    output way_idx_t        victim
);

    always_comb begin
        logic found;
        found  = 1'b0;
        // fallback when every allowed way is valid: the last one scanned
        victim = way_idx_t'(limit - lim_t'(1));
        for (int i = 0; i < WAYS; i++) begin
            if (!found && (lim_t'(i) < limit) && !valid_vec[i]) begin
                victim = way_idx_t'(i);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wrt_access_count.sv
module wrt_access_count
    import wrt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic         hit,
    input  access_mode_e mode,
    input  lim_t         limit,
    output cnt_t         tag_cnt,
    output cnt_t         data_cnt
);

    cnt_t data_step;

    always_comb begin
        if (mode == MODE_SEQUENTIAL)
            data_step = hit ? cnt_t'(1) : '0;
        else
            data_step = cnt_t'(limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_cnt  <= '0;
            data_cnt <= '0;
        end else if (fire) begin
            tag_cnt  <= tag_cnt + cnt_t'(limit);
            data_cnt <= data_cnt + data_step;
        end
    end

endmodule

// File: rtl/way_restricted_tags.sv
module way_restricted_tags
    import wrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lim_wr_en,
    input  logic [LIM_W-1:0]  lim_wr_data,
    output logic [LIM_W-1:0]  limit_out,
    output logic              lim_err,
    input  logic              access_mode,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [WAY_W-1:0]  rsp_victim,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic              inv_en,
    input  logic [SET_W-1:0]  inv_set,
    input  logic [WAY_W-1:0]  inv_way,
    input  logic [SET_W-1:0]  qry_set,
    input  logic [WAY_W-1:0]  qry_way,
    output logic              qry_valid,
    output logic [TAG_W-1:0]  qry_tag,
    output logic [CNT_W-1:0]  tag_acc_cnt,
    output logic [CNT_W-1:0]  data_acc_cnt
);

    lim_t            k_cur;
    logic [WAYS-1:0] valid_vec;
    logic [WAYS-1:0] match_vec;
    tag_entry_t      qry_entry;
    way_idx_t        victim_c;
    lookup_res_t     res_c;
    lookup_res_t     res_q;
    logic            rsp_valid_q;

    wrt_limit_reg u_limit (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lim_wr_en),
        .wr_data (lim_wr_data),
        .limit   (k_cur),
        .reject  (lim_err)
    );

    wrt_tag_store u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_set    (addr_set(lookup_addr)),
        .lk_tag    (addr_tag(lookup_addr)),
        .valid_vec (valid_vec),
        .match_vec (match_vec),
        .wr_fill   (fill_en),
        .wr_set    (addr_set(fill_addr)),
        .wr_way    (fill_way),
        .wr_tag    (addr_tag(fill_addr)),
        .clr_en    (inv_en),
        .clr_set   (inv_set),
        .clr_way   (inv_way),
        .rd_set    (qry_set),
        .rd_way    (qry_way),
        .rd_entry  (qry_entry)
    );

    wrt_victim_pick u_victim (
        .valid_vec (valid_vec),
        .limit     (k_cur),
        .victim    (victim_c)
    );

    // hit compare spans every way, independent of the allocation limit
    always_comb begin
        res_c.hit    = |match_vec;
        res_c.way    = '0;
        res_c.victim = victim_c;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match_vec[i])
                res_c.way = way_idx_t'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            res_q       <= '0;
        end else begin
            rsp_valid_q <= lookup_valid;
            if (lookup_valid)
                res_q <= res_c;
        end
    end

    wrt_access_count u_count (
        .clk      (clk),
        .rst      (rst),
        .fire     (lookup_valid),
        .hit      (res_c.hit),
        .mode     (access_mode_e'(access_mode)),
        .limit    (k_cur),
        .tag_cnt  (tag_acc_cnt),
        .data_cnt (data_acc_cnt)
    );

    assign limit_out  = k_cur;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_hit    = res_q.hit;
    assign rsp_way    = res_q.way;
    assign rsp_victim = res_q.victim;
    assign qry_valid  = qry_entry.valid;
    assign qry_tag    = qry_entry.tag;

endmodule

// File: rtl/wrt_checker.sv
module wrt_checker
    import wrt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lim_wr_en,
    input logic [LIM_W-1:0]  lim_wr_data,
    input logic [LIM_W-1:0]  limit_out,
    input logic              lim_err,
    input logic              access_mode,
    input logic              lookup_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WAY_W-1:0]  rsp_victim,
    input logic [CNT_W-1:0]  tag_acc_cnt,
    input logic [CNT_W-1:0]  data_acc_cnt
);

    p_limit_range_r1: assert property (@(posedge clk) disable iff (rst)
        (limit_out != '0) && (limit_out <= LIM_W'(WAYS)));

    p_reject_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (lim_wr_en && lim_wr_data == '0) |=> (lim_err && limit_out == $past(limit_out)));

    p_clamp_high_r3: assert property (@(posedge clk) disable iff (rst)
        (lim_wr_en && lim_wr_data > LIM_W'(WAYS)) |=> (limit_out == LIM_W'(WAYS) && !lim_err));

    p_rsp_follows_r4: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> rsp_valid);

    p_victim_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> (LIM_W'(rsp_victim) < $past(limit_out)));

    p_tag_step_r6: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> (tag_acc_cnt == $past(tag_acc_cnt) + CNT_W'($past(limit_out))));

    p_seq_data_r7: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && access_mode) |=> (data_acc_cnt == $past(data_acc_cnt) + CNT_W'(rsp_hit)));

    p_par_data_r8: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && !access_mode) |=>
            (data_acc_cnt == $past(data_acc_cnt) + CNT_W'($past(limit_out))));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !lookup_valid |=> ($stable(tag_acc_cnt) && $stable(data_acc_cnt) && !rsp_valid));

endmodule

bind way_restricted_tags wrt_checker u_wrt_checker (
    .clk          (clk),
    .rst          (rst),
    .lim_wr_en    (lim_wr_en),
    .lim_wr_data  (lim_wr_data),
    .limit_out    (limit_out),
    .lim_err      (lim_err),
    .access_mode  (access_mode),
    .lookup_valid (lookup_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_victim   (rsp_victim),
    .tag_acc_cnt  (tag_acc_cnt),
    .data_acc_cnt (data_acc_cnt)
);

// File: tb/way_restricted_tags_test.sv
module way_restricted_tags_test;
    import wrt_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              lim_wr_en;
    logic [LIM_W-1:0]  lim_wr_data;
    logic [LIM_W-1:0]  limit_out;
    logic              lim_err;
    logic              access_mode;
    logic              lookup_valid;
    logic [ADDR_W-1:0] lookup_addr;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [WAY_W-1:0]  rsp_way;
    logic [WAY_W-1:0]  rsp_victim;
    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;
    logic [WAY_W-1:0]  fill_way;
    logic              inv_en;
    logic [SET_W-1:0]  inv_set;
    logic [WAY_W-1:0]  inv_way;
    logic [SET_W-1:0]  qry_set;
    logic [WAY_W-1:0]  qry_way;
    logic              qry_valid;
    logic [TAG_W-1:0]  qry_tag;
    logic [CNT_W-1:0]  tag_acc_cnt;
    logic [CNT_W-1:0]  data_acc_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_tag_cnt  = 0;
    int exp_data_cnt = 0;
    int cur_k        = WAYS;
    bit done         = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    way_restricted_tags uut (.*);

    // {write value, expected limit, expected error pulse}
    localparam int TAB_N = 7;
    localparam logic [2*LIM_W:0] LIM_TAB [TAB_N] = '{
        {4'd2, 4'd2, 1'b0},
        {4'd0, 4'd2, 1'b1},
        {4'd9, 4'd4, 1'b0},
        {4'd4, 4'd4, 1'b0},
        {4'd1, 4'd1, 1'b0},
        {4'd0, 4'd1, 1'b1},
        {4'd3, 4'd3, 1'b0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int tag, int set);
        return {tag_t'(tag), set_idx_t'(set), {OFFSET_W{1'b0}}};
    endfunction

    task automatic set_limit(int v);
        lim_wr_en   = 1'b1;
        lim_wr_data = LIM_W'(v);
        tick();
        lim_wr_en   = 1'b0;
        cur_k       = v;
    endtask

    task automatic fill(int tag, int set, int way);
        fill_en   = 1'b1;
        fill_addr = mk_addr(tag, set);
        fill_way  = WAY_W'(way);
        tick();
        fill_en   = 1'b0;
    endtask

    task automatic lookup(int tag, int set, bit exp_hit, int exp_way, int exp_vic);
        lookup_valid = 1'b1;
        lookup_addr  = mk_addr(tag, set);
        tick();
        lookup_valid = 1'b0;
        exp_tag_cnt += cur_k;
        if (access_mode) exp_data_cnt += exp_hit ? 1 : 0;
        else             exp_data_cnt += cur_k;
        chk("R4 rsp_valid", rsp_valid, 1);
        chk("R4 rsp_hit", rsp_hit, exp_hit);
        if (exp_hit) chk("R4 rsp_way", rsp_way, exp_way);
        chk("R5 rsp_victim", rsp_victim, exp_vic);
        chk("R6 tag_acc_cnt", tag_acc_cnt, exp_tag_cnt);
        if (access_mode) chk("R7 data_acc_cnt", data_acc_cnt, exp_data_cnt);
        else             chk("R8 data_acc_cnt", data_acc_cnt, exp_data_cnt);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lim_wr_en = 1'b0; lim_wr_data = '0; access_mode = 1'b0;
        lookup_valid = 1'b0; lookup_addr = '0; fill_en = 1'b0; fill_addr = '0;
        fill_way = '0; inv_en = 1'b0; inv_set = '0; inv_way = '0;
        qry_set = '0; qry_way = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 limit_out", limit_out, WAYS);
        chk("R1 tag_acc_cnt", tag_acc_cnt, 0);
        chk("R1 data_acc_cnt", data_acc_cnt, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 lim_err", lim_err, 0);
        for (int w = 0; w < WAYS; w++) begin
            qry_set = 4'd1; qry_way = WAY_W'(w); #1;
            chk("R1 qry_valid", qry_valid, 0);
        end

        // limit write table (R2 rejects, R3 accepts and clamps)
        for (int i = 0; i < TAB_N; i++) begin
            lim_wr_en   = 1'b1;
            lim_wr_data = LIM_TAB[i][2*LIM_W -: LIM_W];
            tick();
            lim_wr_en   = 1'b0;
            if (LIM_TAB[i][0]) begin
                chk("R2 limit kept", limit_out, LIM_TAB[i][LIM_W:1]);
                chk("R2 lim_err", lim_err, 1);
            end else begin
                chk("R3 limit_out", limit_out, LIM_TAB[i][LIM_W:1]);
                chk("R3 lim_err", lim_err, 0);
            end
            tick();
            chk("R2 lim_err single pulse", lim_err, 0);
        end
        cur_k = int'(limit_out);

        // parallel mode, limit 2
        set_limit(2);
        lookup(5, 1, 1'b0, 0, 0);
        fill(5, 1, 0);
        qry_set = 4'd1; qry_way = 2'd0; #1;
        chk("R9 qry_valid", qry_valid, 1);
        chk("R9 R10 qry_tag", qry_tag, 5);
        qry_way = 2'd1; #1;
        chk("R9 qry_valid other way", qry_valid, 0);
        lookup(5, 1, 1'b1, 0, 1);
        fill(6, 1, 1);
        lookup(7, 1, 1'b0, 0, 1);       // all allowed ways valid -> k-1
        fill(9, 1, 3);                  // way above the limit
        lookup(9, 1, 1'b1, 3, 1);       // R4 hit above limit

        // sequential mode
        access_mode = 1'b1;
        lookup(9, 1, 1'b1, 3, 1);       // R7 hit adds 1
        lookup(7, 1, 1'b0, 0, 1);       // R7 miss adds 0

        // invalidate
        inv_en = 1'b1; inv_set = 4'd1; inv_way = 2'd0;
        tick();
        inv_en = 1'b0;
        qry_set = 4'd1; qry_way = 2'd0; #1;
        chk("R10 invalidate clears valid", qry_valid, 0);
        lookup(7, 1, 1'b0, 0, 0);

        // idle cycles leave counters alone
        tick(); tick();
        chk("R11 tag_acc_cnt idle", tag_acc_cnt, exp_tag_cnt);
        chk("R11 data_acc_cnt idle", data_acc_cnt, exp_data_cnt);

        // raise limit: first invalid way within the wider range
        set_limit(4);
        lookup(8, 1, 1'b0, 0, 0);
        fill(8, 1, 0);
        lookup(34, 1, 1'b0, 0, 2);
        lookup(5, 2, 1'b0, 0, 0);       // R4 same tag, other set: miss

        // fill and invalidate on same entry: fill wins
        fill_en = 1'b1; fill_addr = mk_addr(51, 2); fill_way = 2'd2;
        inv_en  = 1'b1; inv_set = 4'd2; inv_way = 2'd2;
        tick();
        fill_en = 1'b0; inv_en = 1'b0;
        qry_set = 4'd2; qry_way = 2'd2; #1;
        chk("R10 fill beats invalidate valid", qry_valid, 1);
        chk("R10 fill beats invalidate tag", qry_tag, 51);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule